// File: doc/BRIEF.md
# Pseudo-SRAM Power Sequencer

This block drives the two chip-select controls that put a self-refreshing pseudo-SRAM into standby or deep power-down. Its active-low select, `cs1_n`, is held high (forced standby) whenever an access is not allowed. Its active-high select, `cs2`, is pulled low to enter deep power-down. In deep power-down the memory stops refreshing and its contents are lost. The block tells the access controller when accesses may be issued through `ready`. It takes sleep and wake requests from the system.

All waits are clock-cycle counts derived at elaboration from a clock period given in picoseconds. Each count is rounded up and is never less than one cycle. The long standby hold (300 µs by default) is applied after reset, which stands for power-up, and again after every exit from power-down. A minimum low time for `cs2` (30 ns by default) is always honoured. A sticky `data_lost` flag tells software that the memory must be re-initialised.

Top module: `psram_pwr_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cs1_n`=1, `cs2`=1, `ready`=0 and `data_lost`=0.
- R2: After `rst` falls, `ready` rises exactly HOLD_CYC clock cycles later. HOLD_CYC is ceil(HOLD_NS*1000/CLK_PERIOD_PS), with a minimum of 1. `cs1_n` and `cs2` stay high for that whole time.
- R3: `ready`=1 exactly when `cs1_n`=0, and `cs2`=1 whenever `ready`=1.
- R4: A sleep request (`sleep_req`=1) takes effect only while `ready`=1 and `ctrl_idle`=1. It is then acted on at the next clock edge. In every other case it is ignored.
- R5: When power-down is entered, `cs2` falls at the same clock edge at which `ready` falls and `cs1_n` rises. While `cs2`=0, `cs1_n`=1.
- R6: Each time `cs2` goes low, it stays low for at least LOW_CYC cycles. LOW_CYC is ceil(LOW_NS*1000/CLK_PERIOD_PS), with a minimum of 1. This holds even when a wake request arrives at once.
- R7: A wake request seen during the first LOW_CYC low cycles is remembered, so `cs2` rises after exactly LOW_CYC+1 low cycles. Without any wake request, `cs2` stays low indefinitely.
- R8: After `cs2` rises, `cs1_n` stays high and `ready` stays low for exactly HOLD_CYC cycles, then `ready` rises.
- R9: `data_lost` becomes 1 at the edge where `cs2` falls. It returns to 0 on a clock edge with `lost_ack`=1. If setting and clearing happen at the same edge, setting wins.
- R10: `wake_req` has no effect while `ready`=1 or during the post-reset wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (treated as power-up) |
| sleep_req | input | 1 | Request to enter deep power-down |
| wake_req | input | 1 | Request to leave deep power-down |
| ctrl_idle | input | 1 | Access controller has no transfer in flight |
| lost_ack | input | 1 | Software acknowledge that clears `data_lost` |
| cs1_n | output | 1 | Active-low select to the memory; high forces standby |
| cs2 | output | 1 | Active-high select to the memory; low means deep power-down |
| ready | output | 1 | Accesses may be issued |
| data_lost | output | 1 | Sticky: memory contents were discarded |

## Verification
The hardest situation to reach is a wake request that arrives while `cs2` has only just fallen. The memory has not yet had its minimum low time, so the request must be held and not lost. The bench raises `wake_req` in the cycle straight after the sleep request is accepted and keeps it up. It then counts the low cycles exactly, which exercises both the hold-off and the remembered request.

A second dive is left with no wake request at all. This shows that the block stays powered down and does not time out on its own.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP     = 3'd0,
        ST_READY     = 3'd1,
        ST_PD_ENTRY  = 3'd2,
        ST_PD        = 3'd3,
        ST_WAKE_WAIT = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic cs1_n;
        logic cs2;
        logic ready;
    } pin_ctl_t;

    // Rounded-up cycle count for a delay in ns, never less than one cycle.
    function automatic int ns_to_cycles(input longint ns, input longint clk_ps);
        longint c;
        c = (ns * 64'd1000 + clk_ps - 64'd1) / clk_ps;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic pin_ctl_t decode_pins(input seq_state_e s);
        pin_ctl_t p;
        p.ready = (s == ST_READY);
        p.cs1_n = (s != ST_READY);
        p.cs2   = !((s == ST_PD_ENTRY) || (s == ST_PD));
        return p;
    endfunction

endpackage

// File: rtl/psram_seq_timer.sv
module psram_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != {W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/psram_seq_fsm.sv
module psram_seq_fsm
    import psram_seq_pkg::*;
#(
    parameter int HOLD_CYC = 4,
    parameter int LOW_CYC  = 2,
    parameter int W        = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sleep_req,
    input  logic         wake_req,
    input  logic         ctrl_idle,
    input  logic [W-1:0] cnt,
    output seq_state_e   state,
    output logic         timer_clr,
    output logic         enter_pd
);
    localparam logic [W-1:0] HOLD_LAST = W'(HOLD_CYC - 1);
    localparam logic [W-1:0] LOW_LAST  = W'(LOW_CYC - 1);

    seq_state_e state_nx;
    logic       wake_pend;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PWRUP:     if (cnt == HOLD_LAST) state_nx = ST_READY;
            ST_READY:     if (sleep_req && ctrl_idle) state_nx = ST_PD_ENTRY;
            ST_PD_ENTRY:  if (cnt == LOW_LAST) state_nx = ST_PD;
            ST_PD:        if (wake_req || wake_pend) state_nx = ST_WAKE_WAIT;
            ST_WAKE_WAIT: if (cnt == HOLD_LAST) state_nx = ST_READY;
            default:      state_nx = ST_PWRUP;
        endcase
    end

    assign timer_clr = (state_nx != state);
    assign enter_pd  = (state == ST_READY) && (state_nx == ST_PD_ENTRY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PWRUP;
            wake_pend <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_PD_ENTRY && wake_req) begin
                wake_pend <= 1'b1;
            end else if (state == ST_PD && state_nx == ST_WAKE_WAIT) begin
                wake_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/psram_lost_flag.sv
module psram_lost_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (ack) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
    import psram_seq_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int HOLD_NS       = 300000,
    parameter int LOW_NS        = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic ctrl_idle,
    input  logic lost_ack,
    output logic cs1_n,
    output logic cs2,
    output logic ready,
    output logic data_lost
);
    localparam int HOLD_CYC = ns_to_cycles(longint'(HOLD_NS), longint'(CLK_PERIOD_PS));
    localparam int LOW_CYC  = ns_to_cycles(longint'(LOW_NS), longint'(CLK_PERIOD_PS));
    localparam int CNT_W    = $clog2(max2(HOLD_CYC, LOW_CYC) + 1);

    logic [CNT_W-1:0] cnt;
    logic             timer_clr;
    logic             enter_pd;
    seq_state_e       state;
    pin_ctl_t         pins;

    psram_seq_timer #(.W(CNT_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (timer_clr),
        .cnt (cnt)
    );

    psram_seq_fsm #(
        .HOLD_CYC (HOLD_CYC),
        .LOW_CYC  (LOW_CYC),
        .W        (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .ctrl_idle (ctrl_idle),
        .cnt       (cnt),
        .state     (state),
        .timer_clr (timer_clr),
        .enter_pd  (enter_pd)
    );

    psram_lost_flag u_lost (
        .clk  (clk),
        .rst  (rst),
        .set  (enter_pd),
        .ack  (lost_ack),
        .flag (data_lost)
    );

    assign pins  = decode_pins(state);
    assign cs1_n = pins.cs1_n;
    assign cs2   = pins.cs2;
    assign ready = pins.ready;
endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
    parameter int HOLD_CYC = 4,
    parameter int LOW_CYC  = 2
) (
    input logic clk,
    input logic rst,
    input logic sleep_req,
    input logic ctrl_idle,
    input logic cs1_n,
    input logic cs2,
    input logic ready,
    input logic data_lost
);
    int hi_run;
    int lo_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= 0;
            lo_run <= 0;
        end else begin
            hi_run <= (cs1_n && cs2) ? ((hi_run < HOLD_CYC) ? hi_run + 1 : hi_run) : 0;
            lo_run <= (!cs2) ? ((lo_run < LOW_CYC) ? lo_run + 1 : lo_run) : 0;
        end
    end

    p_ready_sel_r3: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!cs1_n && cs2));
    p_idle_standby_r3: assert property (@(posedge clk) disable iff (rst)
        !ready |-> cs1_n);
    p_sleep_gate_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(cs2) |-> $past(ready && sleep_req && ctrl_idle));
    p_pd_standby_r5: assert property (@(posedge clk) disable iff (rst)
        !cs2 |-> (cs1_n && !ready));
    p_low_min_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cs2) |-> (lo_run >= LOW_CYC));
    p_hold_min_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (hi_run >= HOLD_CYC));
    p_lost_set_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(cs2) |-> data_lost);
endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
    .HOLD_CYC (HOLD_CYC),
    .LOW_CYC  (LOW_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sleep_req (sleep_req),
    .ctrl_idle (ctrl_idle),
    .cs1_n     (cs1_n),
    .cs2       (cs2),
    .ready     (ready),
    .data_lost (data_lost)
);

// File: tb/test_psram_pwr_seq.sv
module test_psram_pwr_seq;
    localparam int CLK_PERIOD_PS = 10000;
    localparam int T_HALF_NS     = 5;
    localparam int HOLD_NS       = 200;
    localparam int LOW_NS        = 45;
    localparam int HOLD          = 20;  // ceil(200000/10000)
    localparam int LOW           = 5;   // ceil(45000/10000)

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0, wake_req = 1'b0, ctrl_idle = 1'b0, lost_ack = 1'b0;
    logic cs1_n, cs2, ready, data_lost;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(T_HALF_NS) clk = ~clk;

    psram_pwr_seq #(
        .CLK_PERIOD_PS (CLK_PERIOD_PS),
        .HOLD_NS       (HOLD_NS),
        .LOW_NS        (LOW_NS)
    ) i_psram_pwr_seq (
        .clk (clk), .rst (rst), .sleep_req (sleep_req), .wake_req (wake_req),
        .ctrl_idle (ctrl_idle), .lost_ack (lost_ack), .cs1_n (cs1_n),
        .cs2 (cs2), .ready (ready), .data_lost (data_lost)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference: 0 wait-after-reset, 1 usable, 2 going down,
    // 3 down, 4 waking. "left" counts down the remaining cycles of a wait.
    int  m_mode = 0;
    int  m_left = HOLD;
    bit  m_pend = 1'b0;
    bit  m_lost = 1'b0;
    bit  started = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_left = HOLD; m_pend = 1'b0; m_lost = 1'b0;
        end else begin
            started = 1'b1;
            case (m_mode)
                0: begin m_left--; if (m_left == 0) m_mode = 1; end
                1: if (sleep_req && ctrl_idle) begin
                       m_mode = 2; m_left = LOW; m_lost = 1'b1;
                   end else if (lost_ack) m_lost = 1'b0;
                2: begin
                       if (wake_req) m_pend = 1'b1;
                       m_left--;
                       if (m_left == 0) m_mode = 3;
                   end
                3: if (wake_req || m_pend) begin
                       m_mode = 4; m_left = HOLD; m_pend = 1'b0;
                   end
                default: begin m_left--; if (m_left == 0) m_mode = 1; end
            endcase
            if (m_mode != 2 && m_mode != 1 && lost_ack) m_lost = 1'b0;
            if (m_mode == 2 && m_left != LOW && lost_ack) m_lost = 1'b0;
        end
    end

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (started && !rst && !done) begin
            chk("R3 ready", int'(ready), int'(m_mode == 1));
            chk("R3 cs1_n", int'(cs1_n), int'(m_mode != 1));
            chk("R5 cs2", int'(cs2), int'(!(m_mode == 2 || m_mode == 3)));
            chk("R9 data_lost", int'(data_lost), int'(m_lost));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int n;
        cyc(3);
        chk("R1 cs1_n in reset", int'(cs1_n), 1);
        chk("R1 cs2 in reset", int'(cs2), 1);
        chk("R1 ready in reset", int'(ready), 0);
        chk("R1 data_lost in reset", int'(data_lost), 0);
        rst = 1'b0;
        wake_req = 1'b1;             // R10: ignored during post-reset wait
        cyc(1);
        chk("R1 ready first cycle", int'(ready), 0);
        chk("R1 cs1_n first cycle", int'(cs1_n), 1);
        n = 1;
        while (!ready && n < 1000) begin
            chk("R2 cs1_n high while waiting", int'(cs1_n), 1);
            chk("R2 cs2 high while waiting", int'(cs2), 1);
            cyc(1); n++;
        end
        chk("R2 cycles to ready", n, HOLD);
        wake_req = 1'b0;

        // R4: sleep without idle is ignored
        sleep_req = 1'b1; ctrl_idle = 1'b0;
        cyc(4);
        chk("R4 no sleep when busy ready", int'(ready), 1);
        chk("R4 no sleep when busy cs2", int'(cs2), 1);
        sleep_req = 1'b0;
        // R10: wake while ready is ignored
        wake_req = 1'b1;
        cyc(3);
        chk("R10 wake while ready", int'(ready), 1);
        wake_req = 1'b0;

        // Enter with simultaneous ack: set wins (R9); wake straight away (R6, R7)
        sleep_req = 1'b1; ctrl_idle = 1'b1; lost_ack = 1'b1;
        cyc(1);
        sleep_req = 1'b0; lost_ack = 1'b0; wake_req = 1'b1;
        chk("R5 cs2 low at entry", int'(cs2), 0);
        chk("R5 ready low at entry", int'(ready), 0);
        chk("R5 cs1_n high at entry", int'(cs1_n), 1);
        chk("R9 set wins over ack", int'(data_lost), 1);
        n = 0;
        while (!cs2 && n < 1000) begin n++; cyc(1); end
        chk("R6 low time at least LOW", int'(n >= LOW), 1);
        chk("R7 remembered wake low cycles", n, LOW + 1);
        wake_req = 1'b0;
        // R4: sleep during wake wait is ignored
        sleep_req = 1'b1;
        cyc(2);
        chk("R4 sleep ignored in wake wait", int'(cs2), 1);
        sleep_req = 1'b0;
        n = 2;
        while (!ready && n < 1000) begin
            chk("R8 cs1_n high during hold", int'(cs1_n), 1);
            n++; cyc(1);
        end
        chk("R8 hold after wake", n, HOLD);

        lost_ack = 1'b1;
        cyc(1);
        lost_ack = 1'b0;
        chk("R9 ack clears", int'(data_lost), 0);

        // Second dive: no wake, stays down
        sleep_req = 1'b1;
        cyc(1);
        sleep_req = 1'b0;
        cyc(LOW + 6);
        chk("R7 stays down without wake", int'(cs2), 0);
        chk("R9 set again", int'(data_lost), 1);
        wake_req = 1'b1;
        cyc(1);
        wake_req = 1'b0;
        chk("R7 exit on wake", int'(cs2), 1);
        cyc(HOLD);
        chk("R8 ready after second wake", int'(ready), 1);
        chk("R9 flag sticky until ack", int'(data_lost), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule